// File: doc/BRIEF.md
# 32-Pin GPIO Bank with Edge Interrupts

This block is one bank of general-purpose I/O pins for a processor subsystem. Software drives pin levels and output enables, reads the pin inputs, and receives an interrupt when a selected pin changes. All pin inputs pass through a two-flop synchroniser before any other logic sees them.

Output levels and output enables are never written directly. Each has one register whose written ones set bits and a second register whose written ones clear bits, so several agents can change different pins without a read-modify-write. Rising and falling edges of the synchronised inputs are detected separately, and each direction has its own per-pin enable. An enabled edge latches a pending bit. Pending bits stay set until software writes a one to them. One combined interrupt line is high while any pending bit is set, and software finds the source pins by reading the pending register.

A pin used as an interrupt source is expected to have its output driver disabled first.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, output levels, output enables, both edge-enable registers and all pending bits are zero, `irq` is low, and every readable offset returns zero.
- R2: A read at offset 0x00 returns the pin levels after the two-flop synchroniser. A change on `pin_in` first appears in the read data three clocks after it is applied when the address is held at 0x00.
- R3: Ones written to offset 0x14 drive those bits of `pin_out` high. Ones written to offset 0x18 drive them low. Bits written as zero keep their value. Both offsets read back the current output levels.
- R4: Ones written to offset 0x1c set those bits of `pin_oe`. Ones written to offset 0x20 clear them. Bits written as zero are unchanged. Both offsets read back the current output enables.
- R5: Offset 0x28 is a read/write per-pin rising-edge enable. Offset 0x2c is a read/write per-pin falling-edge enable.
- R6: A 0-to-1 change of a synchronised input with its rising enable set latches that pin's pending bit. A 1-to-0 change with its falling enable set does the same. A pin with both enables set latches on either edge.
- R7: An edge whose direction is not enabled for that pin leaves the pending register unchanged.
- R8: `irq` is high exactly when at least one pending bit is set.
- R9: Writing ones to offset 0x0c clears those pending bits, and bits written as zero are unaffected. If a new enabled edge on a pin arrives in the same cycle as a clear of that pin, the pending bit stays set.
- R10: Read data appears on `bus_rdata` one clock after the address is presented. Offsets outside the map read as zero.
- R11: Clearing an edge enable does not clear pending bits that are already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one clock after the address |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Output levels driven to the pads |
| pin_oe | output | 32 | Per-pin output driver enables |
| irq | output | 1 | Combined interrupt, high while any bit is pending |

## Verification
On every cycle, the assertions check that a set or clear mask changes exactly the bits it names in the output and enable registers and leaves the other bits alone. They also check that an enabled edge always leaves its pending bit set, and that a pending bit falls only when its pin was in the clear mask. Read-back at each offset, the three-cycle input path, edges that are not enabled, the race between an edge and a clear, and enable changes with bits already pending are exercised only by the bench scenarios. There, a behavioural model is compared against the outputs on every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned PIN_W  = 32;
  localparam int unsigned ADDR_W = 8;

  // Byte offsets of the bank registers
  localparam logic [ADDR_W-1:0] OFF_LEVEL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND    = 8'h0c;
  localparam logic [ADDR_W-1:0] OFF_OUT_SET = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_OUT_CLR = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_OE_SET  = 8'h1c;
  localparam logic [ADDR_W-1:0] OFF_OE_CLR  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RISE_EN = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_FALL_EN = 8'h2c;

  // Write mask for one offset: the write data when that offset is written, else zero
  function automatic logic [PIN_W-1:0] wr_mask(input logic we,
                                               input logic [ADDR_W-1:0] addr,
                                               input logic [ADDR_W-1:0] target,
                                               input logic [PIN_W-1:0] data);
    return (we && (addr == target)) ? data : '0;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] sync_q, sync_d;
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    meta_d = pin_async;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    level = sync_q;
    rise  = sync_q & ~prev_q;
    fall  = ~sync_q & prev_q;
  end
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;
  logic         upd_en;

  always_comb begin
    upd_en = |(set_mask | clr_mask);
    q_d    = (q_r | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd_en) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

  // Every bit named by the set mask is high one clock later (R3/R4).
  assert_set_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((q_r & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));

  // Every bit named by the clear mask is low one clock later (R4).
  assert_clr_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((q_r & $past(clr_mask)) == '0));

  // Bits outside both masks are unchanged (R3).
  assert_unmasked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((q_r ^ $past(q_r)) & ~$past(set_mask | clr_mask)) == '0));
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_en_wr,
  input  logic         fall_en_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ack_mask,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] rise_en,
  output logic [W-1:0] fall_en,
  output logic [W-1:0] pend
);
  logic [W-1:0] ren_q, ren_d;
  logic [W-1:0] fen_q, fen_d;
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] hit;
  logic         pend_upd;

  always_comb begin
    hit      = (rise & ren_q) | (fall & fen_q);
    pend_d   = (pend_q & ~ack_mask) | hit;  // a fresh edge beats the clear
    pend_upd = |(ack_mask | hit);
    ren_d    = wdata;
    fen_d    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q <= '0;
    end else if (rise_en_wr) begin
      ren_q <= ren_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q <= '0;
    end else if (fall_en_wr) begin
      fen_q <= fen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_upd) begin
      pend_q <= pend_d;
    end
  end

  assign rise_en = ren_q;
  assign fall_en = fen_q;
  assign pend    = pend_q;

  // An enabled edge always leaves its pending bit set, even against a clear (R6, R9).
  assert_edge_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & $past(hit)) == $past(hit)));

  // A pending bit falls only for pins in the acknowledge mask (R11).
  assert_pend_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(pend_q) & ~pend_q & ~$past(ack_mask)) == '0));

  // Acknowledged pins without a new edge are clear one clock later (R9).
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & $past(ack_mask & ~hit)) == '0));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W  = PIN_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  logic [W-1:0] level, rise, fall;
  logic [W-1:0] out_set, out_clr, oe_set, oe_clr, ack_mask;
  logic         ren_wr, fen_wr;
  logic [W-1:0] out_q, oe_q, ren, fen, pend;
  logic [W-1:0] rdata_d, rdata_q;

  gpio_in_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
    .level(level), .rise(rise), .fall(fall)
  );

  always_comb begin
    out_set  = wr_mask(bus_we, bus_addr, OFF_OUT_SET, bus_wdata);
    out_clr  = wr_mask(bus_we, bus_addr, OFF_OUT_CLR, bus_wdata);
    oe_set   = wr_mask(bus_we, bus_addr, OFF_OE_SET,  bus_wdata);
    oe_clr   = wr_mask(bus_we, bus_addr, OFF_OE_CLR,  bus_wdata);
    ack_mask = wr_mask(bus_we, bus_addr, OFF_PEND,    bus_wdata);
    ren_wr   = bus_we && (bus_addr == OFF_RISE_EN);
    fen_wr   = bus_we && (bus_addr == OFF_FALL_EN);
  end

  gpio_setclr_reg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .set_mask(out_set), .clr_mask(out_clr), .q(out_q)
  );

  gpio_setclr_reg #(.W(W)) u_oe (
    .clk(clk), .rst_n(rst_n), .set_mask(oe_set), .clr_mask(oe_clr), .q(oe_q)
  );

  gpio_edge_pend #(.W(W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .rise_en_wr(ren_wr), .fall_en_wr(fen_wr), .wdata(bus_wdata),
    .ack_mask(ack_mask), .rise(rise), .fall(fall),
    .rise_en(ren), .fall_en(fen), .pend(pend)
  );

  always_comb begin
    unique case (bus_addr)
      OFF_LEVEL:                rdata_d = level;
      OFF_PEND:                 rdata_d = pend;
      OFF_OUT_SET, OFF_OUT_CLR: rdata_d = out_q;
      OFF_OE_SET,  OFF_OE_CLR:  rdata_d = oe_q;
      OFF_RISE_EN:              rdata_d = ren;
      OFF_FALL_EN:              rdata_d = fen;
      default:                  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = oe_q;
  assign irq       = |pend;

  // A write to the rising enable offset is read back unchanged on the next read (R5).
  assert_rise_en_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && ren_wr) |=> (ren == $past(bus_wdata)));

  // A write to the falling enable offset is read back unchanged on the next read (R5).
  assert_fall_en_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && fen_wr) |=> (fen == $past(bus_wdata)));

  // Unmapped offsets return zero one clock later (R10).
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h04) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_edge_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Behavioural reference model
  logic [31:0] m_s1, m_s2, m_prev, m_out, m_oe, m_ren, m_fen, m_pend, m_rd;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] r, f, p, rd;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_oe = 0;
      m_ren = 0; m_fen = 0; m_pend = 0; m_rd = 0;
    end else begin
      r = m_s2 & ~m_prev;
      f = ~m_s2 & m_prev;
      case (bus_addr)
        8'h00: rd = m_s2;
        8'h0c: rd = m_pend;
        8'h14, 8'h18: rd = m_out;
        8'h1c, 8'h20: rd = m_oe;
        8'h28: rd = m_ren;
        8'h2c: rd = m_fen;
        default: rd = 0;
      endcase
      p = m_pend;
      if (bus_we && bus_addr == 8'h0c) p = p & ~bus_wdata;
      p = p | (r & m_ren) | (f & m_fen);
      if (bus_we) begin
        case (bus_addr)
          8'h14: m_out = m_out | bus_wdata;
          8'h18: m_out = m_out & ~bus_wdata;
          8'h1c: m_oe = m_oe | bus_wdata;
          8'h20: m_oe = m_oe & ~bus_wdata;
          8'h28: m_ren = bus_wdata;
          8'h2c: m_fen = bus_wdata;
          default: ;
        endcase
      end
      m_pend = p; m_rd = rd;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00: return "R2 level read";
      8'h0c: return "R9 pending read";
      8'h14, 8'h18: return "R3 output readback";
      8'h1c, 8'h20: return "R4 enable readback";
      8'h28, 8'h2c: return "R5 edge enable readback";
      default: return "R10 read data";
    endcase
  endfunction

  // Per-clock comparison against the model
  logic [7:0] addr_prev = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pin_out, m_out, "R3 pin_out");
      check(pin_oe, m_oe, "R4 pin_oe");
      check({31'b0, irq}, {31'b0, m_pend != 0}, "R8 irq");
      check(bus_rdata, m_rd, rd_tag(addr_prev));
    end
    addr_prev = bus_addr;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; bus_addr = 8'h04;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    check(bus_rdata, exp, tag);
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bus_addr = 8'h04;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(pin_out, 0, "R1 pin_out"); check(pin_oe, 0, "R1 pin_oe");
    check({31'b0, irq}, 0, "R1 irq");
    rd(8'h0c, 0, "R1 pending"); rd(8'h28, 0, "R1 rise enable");
    rd(8'h2c, 0, "R1 fall enable"); rd(8'h14, 0, "R1 outputs"); rd(8'h1c, 0, "R1 enables");

    // R3 set / clear of output levels
    wr(8'h14, 32'hA5A5_0F0F);
    rd(8'h14, 32'hA5A5_0F0F, "R3 set");
    wr(8'h18, 32'h0000_0F00);
    rd(8'h18, 32'hA5A5_000F, "R3 clear");
    check(pin_out, 32'hA5A5_000F, "R3 pin_out after clear");

    // R4 set / clear of output enables
    wr(8'h1c, 32'hFFFF_0000);
    wr(8'h20, 32'h00FF_0000);
    rd(8'h1c, 32'hFF00_0000, "R4 enable set/clear");
    check(pin_oe, 32'hFF00_0000, "R4 pin_oe");

    // R5 edge enables: pin0 rise, pin2 fall, pin1 both
    wr(8'h28, 32'h3);
    wr(8'h2c, 32'h6);
    rd(8'h28, 32'h3, "R5 rise enable");
    rd(8'h2c, 32'h6, "R5 fall enable");

    // R2 synchroniser delay on pin31 with address held
    @(negedge clk); bus_addr = 8'h00; pin_in = 32'h8000_0000;
    @(negedge clk); check(bus_rdata, 0, "R2 level after 1 clk");
    @(negedge clk); check(bus_rdata, 0, "R2 level after 2 clk");
    @(negedge clk); check(bus_rdata, 32'h8000_0000, "R2 level after 3 clk");
    rd(8'h0c, 0, "R7 pin31 edge not enabled");

    // R6 rising edge on pin0
    pins(32'h8000_0001);
    rd(8'h0c, 32'h1, "R6 rise latch");
    check({31'b0, irq}, 1, "R8 irq high");
    // R7 rising edge on pin2 with only the fall enable
    pins(32'h8000_0005);
    rd(8'h0c, 32'h1, "R7 rise ignored");
    pins(32'h8000_0001);
    rd(8'h0c, 32'h5, "R6 fall latch");
    // pin1 both edges
    pins(32'h8000_0003);
    rd(8'h0c, 32'h7, "R6 both-edge rise");
    wr(8'h0c, 32'h2);
    rd(8'h0c, 32'h5, "R9 clear one bit");
    pins(32'h8000_0001);
    rd(8'h0c, 32'h7, "R6 both-edge fall");
    wr(8'h0c, 32'h1);
    rd(8'h0c, 32'h6, "R9 clear leaves others");

    // R9 edge and clear in the same cycle: edge wins
    @(negedge clk); pin_in = 32'h8000_0003;
    @(negedge clk);
    @(negedge clk); bus_addr = 8'h0c; bus_we = 1'b1; bus_wdata = 32'h2;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0; bus_addr = 8'h04;
    rd(8'h0c, 32'h6, "R9 edge beats clear");
    wr(8'h0c, 32'h2);
    rd(8'h0c, 32'h4, "R9 later clear");

    // R11 disabling the enable keeps the pending bit
    wr(8'h2c, 32'h0);
    rd(8'h0c, 32'h4, "R11 pending kept");
    check({31'b0, irq}, 1, "R8 irq still high");
    wr(8'h0c, 32'hFFFF_FFFF);
    rd(8'h0c, 32'h0, "R9 clear all");
    check({31'b0, irq}, 0, "R8 irq low");

    // R10 unmapped offsets and latency
    rd(8'h30, 0, "R10 unmapped 0x30");
    rd(8'h08, 0, "R10 unmapped 0x08");
    @(negedge clk); bus_addr = 8'h14;
    check(bus_rdata, 0, "R10 old data before edge");
    @(negedge clk); check(bus_rdata, 32'hA5A5_000F, "R10 data one clk later");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule